// File: doc/BRIEF.md
# Unaligned Byte-to-Word Write Merger

This block accepts a byte-granular write request and turns it into a run of aligned, full-width word writes for a parallel flash data bus whose width is two or four bytes. A request carries a start byte address and a byte count. The bytes themselves arrive on a separate stream. The block splits the span into word-aligned slots. If a slot is only partly covered, at the head or at the tail of the request, the block first fetches that word's current contents from the flash read port. Lanes outside the request keep those old bytes. The block then hands each assembled word to a downstream word-program engine and waits for that engine's verdict.

Bytes are packed most-significant lane first, so the lowest byte address of a word sits in its top byte. The request ends when every byte has been written, or at the first word program that returns a nonzero code. The final code goes back on a one-cycle `done` pulse. If the flash vendor has not been recognised, nothing is attempted and code 1 is returned.

Back-pressure rules. A request is taken only on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is high only while the block is idle. A source byte is consumed only on a cycle where `src_valid` and `src_ready` are both high. The producer may hold `src_valid` low for as long as it likes. Once raised, `pgm_valid` stays high with its address and data unchanged until `pgm_ready` is seen.

Top module: `byte_word_merger`

## Requirements
- R1: When `vendor_ok` is low at request acceptance, the block issues no flash read, no program and takes no source byte, and pulses `done` on the next cycle with `result` = 1.
- R2: A request with a byte count of zero, with `vendor_ok` high, completes with `result` = 0 and performs no read, no program and consumes no byte.
- R3: Every `pgm_addr` and `rd_addr` has its low log2(WORD_BYTES) bits zero. The first program targets the start address with those bits cleared, and each later program targets the previous address plus WORD_BYTES.
- R4: In a partial word, lane i (lane 0 = most significant byte) takes the old flash byte when i < offset or when i − offset ≥ remaining count. The offset is the start address modulo WORD_BYTES for the first word and 0 for later words. Every other lane takes the next source byte.
- R5: Source bytes fill lanes in stream order starting at the most significant lane. After a successful run, byte address a holds source byte number a − start.
- R6: A flash read is issued for a word only if that word is partial, meaning its offset is nonzero or fewer than WORD_BYTES bytes remain. Fully covered words are programmed without a read.
- R7: A successful request programs exactly ceil((offset + count) / WORD_BYTES) words and consumes exactly `count` source bytes.
- R8: When a program returns a nonzero `pgm_result`, no further word is programmed and `done` pulses on the next cycle with `result` equal to that code.
- R9: No byte is shifted into the word being assembled unless `src_valid` and `src_ready` are both high.
- R10: `done` is high for exactly one cycle per request, and `req_ready` is high again on the cycle after it.
- R11: While `pgm_valid` is high and `pgm_ready` is low, `pgm_valid`, `pgm_addr` and `pgm_data` hold on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vendor_ok | input | 1 | A supported flash vendor has been identified |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Start byte address |
| req_count | input | CNT_W | Number of bytes to write |
| src_valid | input | 1 | Source byte offered |
| src_ready | output | 1 | Block takes the source byte this cycle |
| src_byte | input | 8 | Source byte |
| rd_req | output | 1 | One-cycle read strobe for the old word |
| rd_addr | output | ADDR_W | Aligned byte address of the word to read |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | WORD_BYTES*8 | Old word contents |
| pgm_valid | output | 1 | Merged word offered to program engine |
| pgm_ready | input | 1 | Program engine takes the word |
| pgm_addr | output | ADDR_W | Aligned byte address of the word |
| pgm_data | output | WORD_BYTES*8 | Merged word |
| pgm_done | input | 1 | Program engine finished the word |
| pgm_result | input | RES_W | Program engine code, 0 = success |
| done | output | 1 | One-cycle completion pulse |
| result | output | RES_W | Final code, valid with `done` |

## Verification
The bench builds the block with WORD_BYTES = 4, a 16-bit address and an 8-bit count. It drives a small flash model holding eight words. Sweeping every start offset across two words against counts from zero to nine reaches all the word shapes: head-only, tail-only, head and tail inside one word, a word partial at both ends, and spans with fully covered middle words. Extra runs inject a failing program at each word index and clear the vendor flag. The source stream stalls on a fixed rhythm and the program engine refuses every other cycle, so both handshakes are exercised against back-pressure.

// File: rtl/merge_pkg.sv
package merge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLAN,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_FILL,
    ST_PGM,
    ST_PGM_WAIT,
    ST_FINISH
  } merge_state_t;

  localparam int unsigned CODE_NO_VENDOR = 1;

endpackage

// File: rtl/lane_planner.sv
module lane_planner #(
  parameter int WORD_BYTES = 4,
  parameter int CNT_W      = 12,
  localparam int LANE_W    = $clog2(WORD_BYTES)
) (
  input  logic              first_word,
  input  logic [LANE_W-1:0] start_off,
  input  logic [CNT_W-1:0]  remaining,
  output logic [LANE_W-1:0] offset,
  output logic              partial,
  output logic [CNT_W-1:0]  span,
  output logic [WORD_BYTES-1:0] take_src
);

  assign offset  = first_word ? start_off : '0;
  assign span    = CNT_W'(WORD_BYTES) - CNT_W'(offset);
  assign partial = (offset != '0) || (remaining < CNT_W'(WORD_BYTES));

  for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
    logic [CNT_W:0] rel;
    assign rel = (CNT_W+1)'(i) - (CNT_W+1)'(offset);
    assign take_src[i] = (LANE_W'(i) >= offset) && (rel < {1'b0, remaining});
  end

endmodule

// File: rtl/word_assembler.sv
module word_assembler #(
  parameter int WORD_BYTES = 4,
  localparam int WORD_W    = WORD_BYTES * 8,
  localparam int LANE_W    = $clog2(WORD_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fill_active,
  input  logic                  capture_old,
  input  logic [WORD_W-1:0]     old_in,
  input  logic [WORD_BYTES-1:0] take_src,
  input  logic                  src_valid,
  output logic                  src_ready,
  input  logic [7:0]            src_byte,
  output logic [WORD_W-1:0]     word,
  output logic                  fill_last
);

  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(WORD_BYTES - 1);

  logic [WORD_W-1:0] old_q;
  logic [WORD_W-1:0] word_q;
  logic [LANE_W-1:0] lane_q;
  logic [7:0]        old_lane [WORD_BYTES];
  logic              use_src;
  logic              step;
  logic [7:0]        new_byte;

  for (genvar i = 0; i < WORD_BYTES; i++) begin : g_unpack
    assign old_lane[i] = old_q[(WORD_BYTES-1-i)*8 +: 8];
  end

  always_comb begin
    use_src   = take_src[lane_q];
    src_ready = fill_active && use_src;
    step      = fill_active && (!use_src || src_valid);
    new_byte  = use_src ? src_byte : old_lane[lane_q];
    fill_last = step && (lane_q == LAST_LANE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_q  <= '0;
      word_q <= '0;
      lane_q <= '0;
    end else begin
      if (capture_old) old_q <= old_in;
      if (!fill_active) begin
        lane_q <= '0;
      end else if (step) begin
        lane_q <= lane_q + 1'b1;
        word_q <= {word_q[WORD_W-9:0], new_byte};
      end
    end
  end

  assign word = word_q;

  AST_NO_SHIFT_WITHOUT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ready && !src_valid) |=> $stable(word_q)); // R9

endmodule

// File: rtl/merge_ctrl.sv
module merge_ctrl
  import merge_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 12,
  parameter int RES_W      = 4,
  localparam int LANE_W    = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vendor_ok,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              partial,
  input  logic [CNT_W-1:0]  span,
  output logic              first_word,
  output logic [LANE_W-1:0] start_off,
  output logic [CNT_W-1:0]  remaining,
  output logic              fill_active,
  input  logic              fill_last,
  output logic              capture_old,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  output logic              pgm_valid,
  input  logic              pgm_ready,
  output logic [ADDR_W-1:0] pgm_addr,
  input  logic              pgm_done,
  input  logic [RES_W-1:0]  pgm_result,
  output logic              done,
  output logic [RES_W-1:0]  result
);

  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(WORD_BYTES - 1);

  merge_state_t      st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [LANE_W-1:0] off_q;
  logic [CNT_W-1:0]  rem_q;
  logic              first_q;
  logic [RES_W-1:0]  res_q;
  logic              accept;
  logic              last_word;

  assign accept    = (st_q == ST_IDLE) && req_valid;
  assign last_word = (rem_q <= span);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        if (!vendor_ok || req_count == '0) st_d = ST_FINISH;
        else                               st_d = ST_PLAN;
      end
      ST_PLAN:     st_d = partial ? ST_RD_REQ : ST_FILL;
      ST_RD_REQ:   st_d = ST_RD_WAIT;
      ST_RD_WAIT:  if (rd_valid) st_d = ST_FILL;
      ST_FILL:     if (fill_last) st_d = ST_PGM;
      ST_PGM:      if (pgm_ready) st_d = ST_PGM_WAIT;
      ST_PGM_WAIT: if (pgm_done) begin
        if (pgm_result != '0 || last_word) st_d = ST_FINISH;
        else                               st_d = ST_PLAN;
      end
      ST_FINISH:   st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      off_q   <= '0;
      rem_q   <= '0;
      first_q <= 1'b0;
      res_q   <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        addr_q  <= req_addr & ~LOW_MASK;
        off_q   <= LANE_W'(req_addr & LOW_MASK);
        rem_q   <= req_count;
        first_q <= 1'b1;
        res_q   <= vendor_ok ? '0 : RES_W'(CODE_NO_VENDOR);
      end else if (st_q == ST_PGM_WAIT && pgm_done) begin
        if (pgm_result != '0) begin
          res_q <= pgm_result;
        end else begin
          addr_q  <= addr_q + ADDR_W'(WORD_BYTES);
          rem_q   <= last_word ? '0 : rem_q - span;
          first_q <= 1'b0;
        end
      end
    end
  end

  assign req_ready   = (st_q == ST_IDLE);
  assign first_word  = first_q;
  assign start_off   = off_q;
  assign remaining   = rem_q;
  assign fill_active = (st_q == ST_FILL);
  assign capture_old = (st_q == ST_RD_WAIT) && rd_valid;
  assign rd_req      = (st_q == ST_RD_REQ);
  assign rd_addr     = addr_q;
  assign pgm_valid   = (st_q == ST_PGM);
  assign pgm_addr    = addr_q;
  assign done        = (st_q == ST_FINISH);
  assign result      = res_q;

  AST_VENDOR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !vendor_ok) |=> (done && result == RES_W'(CODE_NO_VENDOR))); // R1
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_valid || rd_req) |-> ((pgm_addr & LOW_MASK) == '0)); // R3
  AST_READ_ONLY_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> partial); // R6
  AST_STOP_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PGM_WAIT && pgm_done && pgm_result != '0) |=> (done && result == $past(pgm_result))); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready)); // R10

endmodule

// File: rtl/byte_word_merger.sv
module byte_word_merger #(
  parameter int WORD_BYTES = 4,
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 12,
  parameter int RES_W      = 4,
  localparam int WORD_W    = WORD_BYTES * 8,
  localparam int LANE_W    = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vendor_ok,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [7:0]        src_byte,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_data,
  output logic              pgm_valid,
  input  logic              pgm_ready,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [WORD_W-1:0] pgm_data,
  input  logic              pgm_done,
  input  logic [RES_W-1:0]  pgm_result,
  output logic              done,
  output logic [RES_W-1:0]  result
);

  logic                  first_word;
  logic [LANE_W-1:0]     start_off;
  logic [CNT_W-1:0]      remaining;
  logic [LANE_W-1:0]     offset;
  logic                  partial;
  logic [CNT_W-1:0]      span;
  logic [WORD_BYTES-1:0] take_src;
  logic                  fill_active;
  logic                  fill_last;
  logic                  capture_old;

  lane_planner #(.WORD_BYTES(WORD_BYTES), .CNT_W(CNT_W)) u_plan (
    .first_word (first_word),
    .start_off  (start_off),
    .remaining  (remaining),
    .offset     (offset),
    .partial    (partial),
    .span       (span),
    .take_src   (take_src)
  );

  word_assembler #(.WORD_BYTES(WORD_BYTES)) u_asm (
    .clk         (clk),
    .rst_n       (rst_n),
    .fill_active (fill_active),
    .capture_old (capture_old),
    .old_in      (rd_data),
    .take_src    (take_src),
    .src_valid   (src_valid),
    .src_ready   (src_ready),
    .src_byte    (src_byte),
    .word        (pgm_data),
    .fill_last   (fill_last)
  );

  merge_ctrl #(
    .WORD_BYTES (WORD_BYTES),
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .RES_W      (RES_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .vendor_ok   (vendor_ok),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_count   (req_count),
    .partial     (partial),
    .span        (span),
    .first_word  (first_word),
    .start_off   (start_off),
    .remaining   (remaining),
    .fill_active (fill_active),
    .fill_last   (fill_last),
    .capture_old (capture_old),
    .rd_req      (rd_req),
    .rd_addr     (rd_addr),
    .rd_valid    (rd_valid),
    .pgm_valid   (pgm_valid),
    .pgm_ready   (pgm_ready),
    .pgm_addr    (pgm_addr),
    .pgm_done    (pgm_done),
    .pgm_result  (pgm_result),
    .done        (done),
    .result      (result)
  );

  AST_PGM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_valid && !pgm_ready) |=> (pgm_valid && $stable(pgm_addr) && $stable(pgm_data))); // R11

endmodule

// File: tb/sim_byte_word_merger.sv
module sim_byte_word_merger;

  localparam int WB     = 4;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 8;
  localparam int RES_W  = 4;
  localparam int WW     = WB * 8;
  localparam int NW     = 8;
  localparam int NB     = NW * WB;
  localparam logic [RES_W-1:0] FAIL_CODE = 4'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              vendor_ok = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [CNT_W-1:0]  req_count = '0;
  logic              src_valid;
  logic              src_ready;
  logic [7:0]        src_byte;
  logic              rd_req;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_valid = 1'b0;
  logic [WW-1:0]     rd_data = '0;
  logic              pgm_valid;
  logic              pgm_ready;
  logic [ADDR_W-1:0] pgm_addr;
  logic [WW-1:0]     pgm_data;
  logic              pgm_done = 1'b0;
  logic [RES_W-1:0]  pgm_result = '0;
  logic              done;
  logic [RES_W-1:0]  result;

  byte_word_merger #(.WORD_BYTES(WB), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RES_W(RES_W)) u0 (
    .clk(clk), .rst_n(rst_n), .vendor_ok(vendor_ok),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_count(req_count),
    .src_valid(src_valid), .src_ready(src_ready), .src_byte(src_byte),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .pgm_valid(pgm_valid), .pgm_ready(pgm_ready), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .pgm_done(pgm_done), .pgm_result(pgm_result), .done(done), .result(result)
  );

  int tchk = 0, tfail = 0, mchk = 0, mfail = 0;
  int tid = 0;
  int src_base = 0, pgm_base = 0, fail_at = -1, first_word_addr = 0;
  logic src_on = 1'b0, init_mem = 1'b0;

  int cyc = 0, src_idx = 0, pgm_cnt = 0, rd_cnt = 0, pend = 0;
  logic [WW-1:0] mem [NW];
  logic [WW-1:0] pend_data;
  int pend_word = 0;
  logic pend_fail = 1'b0, hold_prev = 1'b0;
  logic [WW-1:0] hold_data;
  logic [ADDR_W-1:0] hold_addr;
  logic [7:0] emem [NB];

  function automatic logic [7:0] src_pat(int t, int j);
    return 8'((t * 13 + j * 5 + 1) & 255);
  endfunction
  function automatic logic [7:0] init_pat(int t, int b);
    return 8'((8'h3C + b * 11 + t * 3) & 255);
  endfunction

  assign src_valid = src_on && (cyc % 4 != 1);
  assign src_byte  = src_pat(tid, src_idx - src_base);
  assign pgm_ready = (cyc % 2 == 0);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (src_valid && src_ready) src_idx <= src_idx + 1;
    rd_valid <= rd_req;
    if (rd_req) begin
      rd_cnt  <= rd_cnt + 1;
      rd_data <= mem[(int'(rd_addr) / WB) % NW];
      mchk <= mchk + 1;
      if (rd_addr % WB != 0) begin
        mfail <= mfail + 1;
        $display("FAIL R3 read address %0d not aligned, expected multiple of %0d", rd_addr, WB);
      end
    end
    hold_prev <= pgm_valid && !pgm_ready;
    hold_data <= pgm_data;
    hold_addr <= pgm_addr;
    if (hold_prev) begin
      mchk <= mchk + 1;
      if (!pgm_valid || pgm_data != hold_data || pgm_addr != hold_addr) begin
        mfail <= mfail + 1;
        $display("FAIL R11 stalled offer changed: valid %0b data %h addr %0d, expected 1 %h %0d",
                 pgm_valid, pgm_data, pgm_addr, hold_data, hold_addr);
      end
    end
    pgm_done <= 1'b0;
    if (pgm_valid && pgm_ready) begin
      mchk <= mchk + 1;
      if (int'(pgm_addr) != first_word_addr + (pgm_cnt - pgm_base) * WB) begin
        mfail <= mfail + 1;
        $display("FAIL R3 program address %0d, expected %0d", pgm_addr,
                 first_word_addr + (pgm_cnt - pgm_base) * WB);
      end
      pend      <= 2;
      pend_data <= pgm_data;
      pend_word <= (int'(pgm_addr) / WB) % NW;
      pend_fail <= (pgm_cnt - pgm_base) == fail_at;
      pgm_cnt   <= pgm_cnt + 1;
    end else if (pend > 0) begin
      pend <= pend - 1;
      if (pend == 1) begin
        pgm_done   <= 1'b1;
        pgm_result <= pend_fail ? FAIL_CODE : '0;
        if (!pend_fail) mem[pend_word] <= pend_data;
      end
    end
    if (init_mem)
      for (int w = 0; w < NW; w++)
        for (int i = 0; i < WB; i++)
          mem[w][(WB-1-i)*8 +: 8] <= init_pat(tid, w * WB + i);
  end

  task automatic check(bit ok, string tag, int act, int exp);
    tchk++;
    if (!ok) begin
      tfail++;
      $display("FAIL %s actual %0d expected %0d (a=%0d n=%0d)", tag, act, exp, req_addr, req_count);
    end
  endtask

  task automatic run(int a, int n, bit vok, int fa);
    int s0, p0, r0, cycles, exp_res, exp_pg, exp_rd, exp_b, ws, nwords, lo, hi, mism;
    logic [RES_W-1:0] got;
    @(negedge clk);
    tid = tid + 1;
    init_mem = 1'b1;
    @(negedge clk);
    init_mem = 1'b0;
    for (int b = 0; b < NB; b++) emem[b] = init_pat(tid, b);
    s0 = src_idx; p0 = pgm_cnt; r0 = rd_cnt;
    src_base = s0; pgm_base = p0; fail_at = fa;
    first_word_addr = (a / WB) * WB;
    vendor_ok = vok; req_addr = ADDR_W'(a); req_count = CNT_W'(n);
    src_on = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cycles = 0;
    while (!done && cycles < 2000) begin
      @(negedge clk);
      cycles++;
    end
    got = result;
    check(done == 1'b1, "R10 done seen", int'(done), 1);
    @(negedge clk);
    check(!done && req_ready, "R10 done single pulse, ready after", int'(done), 0);
    src_on = 1'b0;
    exp_pg = 0; exp_rd = 0; exp_b = 0; exp_res = 0;
    if (!vok) exp_res = 1;
    else if (n > 0) begin
      ws = a / WB;
      nwords = (a + n - 1) / WB - ws + 1;
      for (int k = 0; k < nwords; k++) begin
        if (fa >= 0 && k > fa) break;
        lo = ((ws + k) * WB > a) ? (ws + k) * WB : a;
        hi = ((ws + k + 1) * WB < a + n) ? (ws + k + 1) * WB : a + n;
        exp_pg++;
        if (hi - lo < WB) exp_rd++;
        exp_b += hi - lo;
        if (k == fa) exp_res = FAIL_CODE;
        else for (int x = lo; x < hi; x++) emem[x] = src_pat(tid, x - a);
      end
    end
    if (!vok) begin
      check(got == 1 && pgm_cnt == p0 && rd_cnt == r0 && src_idx == s0,
            "R1 vendor missing: result/no activity", int'(got), 1);
    end else if (n == 0) begin
      check(got == 0 && pgm_cnt == p0 && rd_cnt == r0 && src_idx == s0,
            "R2 empty request", int'(got), 0);
    end else begin
      check(int'(got) == exp_res, fa >= 0 ? "R8 result code" : "R7 result code", int'(got), exp_res);
      check(pgm_cnt - p0 == exp_pg, fa >= 0 ? "R8 words programmed" : "R7 words programmed",
            pgm_cnt - p0, exp_pg);
      check(rd_cnt - r0 == exp_rd, "R6 reads issued", rd_cnt - r0, exp_rd);
      check(src_idx - s0 == exp_b, "R7 R9 bytes consumed", src_idx - s0, exp_b);
      mism = 0;
      for (int w = 0; w < NW; w++)
        for (int i = 0; i < WB; i++)
          if (mem[w][(WB-1-i)*8 +: 8] != emem[w * WB + i]) mism++;
      check(mism == 0, "R4 R5 flash image bytes wrong", mism, 0);
    end
    repeat (3) @(negedge clk);
    check(!src_ready && !pgm_valid && !rd_req, "R9 quiet while idle", int'(src_ready), 0);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    tfail++; tchk++;
    $display("FAIL watchdog expired, actual hung expected done");
    $display("%0d/%0d checks passed", tchk + mchk - tfail - mfail, tchk + mchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tchk++;
    if (req_ready !== 1'b1 || done !== 1'b0 || src_ready !== 1'b0 || pgm_valid !== 1'b0 || rd_req !== 1'b0) begin
      tfail++;
      $display("FAIL R10 reset state: ready %b done %b, expected 1 0", req_ready, done);
    end
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++)
      for (int n = 0; n < 10; n++)
        run(a, n, 1'b1, -1);
    run(5, 20, 1'b1, -1);
    for (int f = 0; f < 4; f++) run(3, 12, 1'b1, f);
    run(4, 16, 1'b1, 2);
    run(2, 6, 1'b0, -1);
    run(0, 0, 1'b0, -1);
    $display("%0d/%0d checks passed", tchk + mchk - tfail - mfail, tchk + mchk);
    $finish;
  end

endmodule